// File: doc/BRIEF.md
# Dual-Target Level Interrupt Bank

This block gathers 32 level-sensitive interrupt lines and presents them to two processors: a main CPU, which has a normal interrupt output and a fast interrupt output, and a coprocessor, which has a single interrupt output. Software reaches the block through a simple word-wide register bus. Each processor has its own per-line enable mask. The CPU also has a class mask that sends each of its enabled lines to either the normal output or the fast output. A software force mask makes any line pending without its input, so a driver can retrigger an interrupt that it has already handled.

Each mutable mask has three addresses. A base address reads the mask and loads it whole. A set alias ORs the written word into the mask. A clear alias removes every written 1 from the mask. A driver can therefore change single lines without a read-modify-write. It can also save all enables by reading the base address, then restore them by writing all ones to the clear alias followed by the saved word to the set alias.

Top module: `lic_bank`

## Requirements
- R1: After reset, the force, CPU enable, CPU class, coprocessor enable and coprocessor class masks are all zero, and `cpu_irq`, `cpu_fiq` and `cop_irq` are low.
- R2: A write to 0x24 ORs the written word into the CPU enable mask. A write to 0x28 clears every mask bit whose written bit is 1. Zero bits leave their lines unchanged. Writing all ones to 0x28 disables every line.
- R3: A write to a base address (0x14 force, 0x20 CPU enable, 0x30 coprocessor enable) loads the whole mask. A write to a class address (0x2C CPU, 0x3C coprocessor) loads that class mask.
- R4: The force mask is at 0x14, with a set alias at 0x18 and a clear alias at 0x1C that behave like the enable aliases.
- R5: Line n (bit n of every register) is pending when `irq_in[n]` is high or force bit n is 1.
- R6: A CPU class bit of 0 sends its line to `cpu_irq`, and a class bit of 1 sends it to `cpu_fiq`.
- R7: `cpu_irq` is the OR of pending & CPU enable & ~class, and `cpu_fiq` is the OR of pending & CPU enable & class. Both outputs follow `irq_in` in the same cycle and follow a register write from the cycle after it.
- R8: The coprocessor enable mask sits at 0x30 with aliases at 0x34 (set) and 0x38 (clear). `cop_irq` is the OR of pending & coprocessor enable. The coprocessor class mask at 0x3C is stored and can be read back, but it has no effect on any output.
- R9: Address 0x08 is read-only and returns pending & CPU enable & CPU class, which are the lines that currently drive `cpu_fiq`. Writes to 0x08 change nothing.
- R10: A read of a set or clear alias returns the current value of its base mask.
- R11: Writes to any other address change no state, and reads of any other address return zero.
- R12: Read data is registered. `rsp_rdata` carries the value read in the cycle after a read request, and it is zero in the cycle after any cycle with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid one cycle after a read request |
| irq_in | input | 32 | Level-sensitive interrupt lines |
| cpu_irq | output | 1 | CPU normal interrupt |
| cpu_fiq | output | 1 | CPU fast interrupt |
| cop_irq | output | 1 | Coprocessor interrupt |

## Verification
The assertions assume that each bus request is a single cycle that carries its address and data in that cycle, and that `req_write` and `req_addr` are known whenever `req_valid` is high. The stimulus drives every bus field and interrupt input a fixed time after each rising edge, so nothing changes at an edge. It returns `req_valid` low after each directed transfer. Random phases draw addresses from the mapped set mixed with unmapped, unaligned and out-of-range addresses. They also draw sparse interrupt patterns, so that both the pending and the idle cases of each output are exercised.

// File: rtl/lic_bank_pkg.sv
package lic_bank_pkg;

    // Register offsets; the set/clear alias arrangement is decoded as a trio
    localparam logic [7:0] OFS_FIQ_STAT = 8'h08;
    localparam logic [7:0] OFS_FRC      = 8'h14;
    localparam logic [7:0] OFS_FRC_SET  = 8'h18;
    localparam logic [7:0] OFS_FRC_CLR  = 8'h1C;
    localparam logic [7:0] OFS_CEN      = 8'h20;
    localparam logic [7:0] OFS_CEN_SET  = 8'h24;
    localparam logic [7:0] OFS_CEN_CLR  = 8'h28;
    localparam logic [7:0] OFS_CCLS     = 8'h2C;
    localparam logic [7:0] OFS_PEN      = 8'h30;
    localparam logic [7:0] OFS_PEN_SET  = 8'h34;
    localparam logic [7:0] OFS_PEN_CLR  = 8'h38;
    localparam logic [7:0] OFS_PCLS     = 8'h3C;

    // Index of each stored mask in the register array
    localparam int RI_FRC  = 0;
    localparam int RI_CEN  = 1;
    localparam int RI_CCLS = 2;
    localparam int RI_PEN  = 3;
    localparam int RI_PCLS = 4;
    localparam int NREG    = 5;

    typedef struct packed {
        logic ld;
        logic set;
        logic clr;
    } mask_op_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FIQ,
        SEL_FRC,
        SEL_CEN,
        SEL_CCLS,
        SEL_PEN,
        SEL_PCLS
    } rsel_t;

endpackage

// File: rtl/lic_addr_dec.sv
module lic_addr_dec
    import lic_bank_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [AW-1:0]             req_addr,
    output mask_op_t [NREG-1:0]       ops,
    output rsel_t                     rsel,
    output logic                      rd_en
);

    logic wr;

    always_comb begin
        wr    = req_valid && req_write;
        rd_en = req_valid && !req_write;
        ops   = '0;
        rsel  = SEL_NONE;
        case (req_addr)
            AW'(OFS_FIQ_STAT): rsel = SEL_FIQ;
            AW'(OFS_FRC):     begin rsel = SEL_FRC;  ops[RI_FRC].ld  = wr; end
            AW'(OFS_FRC_SET): begin rsel = SEL_FRC;  ops[RI_FRC].set = wr; end
            AW'(OFS_FRC_CLR): begin rsel = SEL_FRC;  ops[RI_FRC].clr = wr; end
            AW'(OFS_CEN):     begin rsel = SEL_CEN;  ops[RI_CEN].ld  = wr; end
            AW'(OFS_CEN_SET): begin rsel = SEL_CEN;  ops[RI_CEN].set = wr; end
            AW'(OFS_CEN_CLR): begin rsel = SEL_CEN;  ops[RI_CEN].clr = wr; end
            AW'(OFS_CCLS):    begin rsel = SEL_CCLS; ops[RI_CCLS].ld = wr; end
            AW'(OFS_PEN):     begin rsel = SEL_PEN;  ops[RI_PEN].ld  = wr; end
            AW'(OFS_PEN_SET): begin rsel = SEL_PEN;  ops[RI_PEN].set = wr; end
            AW'(OFS_PEN_CLR): begin rsel = SEL_PEN;  ops[RI_PEN].clr = wr; end
            AW'(OFS_PCLS):    begin rsel = SEL_PCLS; ops[RI_PCLS].ld = wr; end
            default:          rsel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/lic_mask_reg.sv
module lic_mask_reg
    import lic_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mask_op_t     op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] val;
    } mreg_t;

    mreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op.ld) begin
            st_d.val = wdata;
        end else if (op.set) begin
            st_d.val = st_q.val | wdata;
        end else if (op.clr) begin
            st_d.val = st_q.val & ~wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

endmodule

// File: rtl/lic_route.sv
module lic_route #(
    parameter int W = 32
) (
    input  logic [W-1:0] irq_in,
    input  logic [W-1:0] frc,
    input  logic [W-1:0] cen,
    input  logic [W-1:0] ccls,
    input  logic [W-1:0] pen,
    output logic [W-1:0] fiq_lines,
    output logic         cpu_irq,
    output logic         cpu_fiq,
    output logic         cop_irq
);

    logic [W-1:0] pend;
    logic [W-1:0] irq_lines;

    always_comb begin
        pend      = irq_in | frc;
        irq_lines = pend & cen & ~ccls;
        fiq_lines = pend & cen & ccls;
        cpu_irq   = |irq_lines;
        cpu_fiq   = |fiq_lines;
        cop_irq   = |(pend & pen);
    end

endmodule

// File: rtl/lic_bank.sv
module lic_bank
    import lic_bank_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [NLINES-1:0] req_wdata,
    output logic [NLINES-1:0] rsp_rdata,
    input  logic [NLINES-1:0] irq_in,
    output logic              cpu_irq,
    output logic              cpu_fiq,
    output logic              cop_irq
);

    typedef struct packed {
        logic [NLINES-1:0] rdata;
    } bus_st_t;

    mask_op_t [NREG-1:0] ops;
    rsel_t               rsel;
    logic                rd_en;
    logic [NLINES-1:0]   regs [NREG];
    logic [NLINES-1:0]   fiq_lines;
    logic [NLINES-1:0]   frc_q, cen_q, ccls_q, pen_q, pcls_q;
    bus_st_t             st_d, st_q;

    lic_addr_dec #(.AW(AW)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .ops       (ops),
        .rsel      (rsel),
        .rd_en     (rd_en)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_mask
        lic_mask_reg #(.W(NLINES)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .op    (ops[g]),
            .wdata (req_wdata),
            .q     (regs[g])
        );
    end

    assign frc_q  = regs[RI_FRC];
    assign cen_q  = regs[RI_CEN];
    assign ccls_q = regs[RI_CCLS];
    assign pen_q  = regs[RI_PEN];
    assign pcls_q = regs[RI_PCLS];

    lic_route #(.W(NLINES)) u_route (
        .irq_in    (irq_in),
        .frc       (frc_q),
        .cen       (cen_q),
        .ccls      (ccls_q),
        .pen       (pen_q),
        .fiq_lines (fiq_lines),
        .cpu_irq   (cpu_irq),
        .cpu_fiq   (cpu_fiq),
        .cop_irq   (cop_irq)
    );

    always_comb begin
        st_d.rdata = '0;
        if (rd_en) begin
            case (rsel)
                SEL_FIQ:  st_d.rdata = fiq_lines;
                SEL_FRC:  st_d.rdata = frc_q;
                SEL_CEN:  st_d.rdata = cen_q;
                SEL_CCLS: st_d.rdata = ccls_q;
                SEL_PEN:  st_d.rdata = pen_q;
                SEL_PCLS: st_d.rdata = pcls_q;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_rdata = st_q.rdata;

endmodule

// File: rtl/lic_bank_chk.sv
module lic_bank_chk
    import lic_bank_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic [W-1:0]  req_wdata,
    input logic [W-1:0]  rsp_rdata,
    input logic [W-1:0]  irq_in,
    input logic          cpu_irq,
    input logic          cpu_fiq,
    input logic          cop_irq,
    input logic [W-1:0]  frc_q,
    input logic [W-1:0]  cen_q,
    input logic [W-1:0]  ccls_q,
    input logic [W-1:0]  pen_q,
    input logic [W-1:0]  pcls_q
);

    logic mapped;
    logic wr;

    always_comb begin
        wr = req_valid && req_write;
        mapped = (req_addr == AW'(OFS_FIQ_STAT)) ||
                 (req_addr == AW'(OFS_FRC))  || (req_addr == AW'(OFS_FRC_SET)) ||
                 (req_addr == AW'(OFS_FRC_CLR)) || (req_addr == AW'(OFS_CEN)) ||
                 (req_addr == AW'(OFS_CEN_SET)) || (req_addr == AW'(OFS_CEN_CLR)) ||
                 (req_addr == AW'(OFS_CCLS)) || (req_addr == AW'(OFS_PEN)) ||
                 (req_addr == AW'(OFS_PEN_SET)) || (req_addr == AW'(OFS_PEN_CLR)) ||
                 (req_addr == AW'(OFS_PCLS));
    end

    // R2
    cen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == AW'(OFS_CEN_SET)) |=> ((cen_q & $past(req_wdata)) == $past(req_wdata)));

    // R2
    cen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && req_addr == AW'(OFS_CEN_CLR)) |=> ((cen_q & $past(req_wdata)) == '0));

    // R7
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (|((irq_in | frc_q) & cen_q)));

    // R6
    fiq_needs_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fiq |-> (|(cen_q & ccls_q)));

    // R8
    cop_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq |-> (|((irq_in | frc_q) & pen_q)));

    // R11
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mapped) |=> ($stable(frc_q) && $stable(cen_q) && $stable(ccls_q) &&
                             $stable(pen_q) && $stable(pcls_q)));

    // R12
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (rsp_rdata == '0));

endmodule

bind lic_bank lic_bank_chk #(.W(NLINES), .AW(AW)) i_lic_bank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .irq_in    (irq_in),
    .cpu_irq   (cpu_irq),
    .cpu_fiq   (cpu_fiq),
    .cop_irq   (cop_irq),
    .frc_q     (frc_q),
    .cen_q     (cen_q),
    .ccls_q    (ccls_q),
    .pen_q     (pen_q),
    .pcls_q    (pcls_q)
);

// File: tb/test_lic_bank.sv
`timescale 1ns/1ps
module test_lic_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [31:0] irq_in = '0;
    logic        cpu_irq, cpu_fiq, cop_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    logic [31:0] m_frc, m_cen, m_ccls, m_pen, m_pcls;

    always #2 clk = ~clk;

    lic_bank i_lic_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .irq_in(irq_in), .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq), .cop_irq(cop_irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(logic [7:0] a, logic [31:0] irq);
        case (a)
            8'h08: return (irq | m_frc) & m_cen & m_ccls;
            8'h14, 8'h18, 8'h1C: return m_frc;
            8'h20, 8'h24, 8'h28: return m_cen;
            8'h2C: return m_ccls;
            8'h30, 8'h34, 8'h38: return m_pen;
            8'h3C: return m_pcls;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(logic [7:0] a, logic [31:0] d);
        case (a)
            8'h14: m_frc = d;
            8'h18: m_frc = m_frc | d;
            8'h1C: m_frc = m_frc & ~d;
            8'h20: m_cen = d;
            8'h24: m_cen = m_cen | d;
            8'h28: m_cen = m_cen & ~d;
            8'h2C: m_ccls = d;
            8'h30: m_pen = d;
            8'h34: m_pen = m_pen | d;
            8'h38: m_pen = m_pen & ~d;
            8'h3C: m_pcls = d;
            default: ;
        endcase
    endtask

    task automatic check_outputs(string tag);
        logic [31:0] p;
        p = irq_in | m_frc;
        chk({tag, " cpu_irq"}, {31'b0, cpu_irq}, {31'b0, |(p & m_cen & ~m_ccls)});
        chk({tag, " cpu_fiq"}, {31'b0, cpu_fiq}, {31'b0, |(p & m_cen & m_ccls)});
        chk({tag, " cop_irq"}, {31'b0, cop_irq}, {31'b0, |(p & m_pen)});
    endtask

    // one bus cycle; state and read data checked one edge later
    task automatic cycle(string tag, bit v, bit w, logic [7:0] a, logic [31:0] d,
                         logic [31:0] irq);
        logic [31:0] exp_rd;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; irq_in = irq;
        exp_rd = (v && !w) ? model_read(a, irq) : 32'h0;
        @(posedge clk);
        #1;
        if (v && w) model_write(a, d);
        chk({tag, " rdata R12"}, rsp_rdata, exp_rd);
        check_outputs(tag);
        req_valid = 1'b0;
    endtask

    task automatic wr(string tag, logic [7:0] a, logic [31:0] d);
        cycle(tag, 1'b1, 1'b1, a, d, irq_in);
    endtask

    task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
        cycle(tag, 1'b1, 1'b0, a, 32'h0, irq_in);
        chk({tag, " readback"}, rsp_rdata, exp);
    endtask

    task automatic idle(string tag, logic [31:0] irq);
        cycle(tag, 1'b0, 1'b0, 8'h00, 32'h0, irq);
    endtask

    initial begin
        m_frc = '0; m_cen = '0; m_ccls = '0; m_pen = '0; m_pcls = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check_outputs("R1");
        chk("R1 rdata", rsp_rdata, 32'h0);
        rd("R1 frc", 8'h14, 32'h0);
        rd("R1 cen", 8'h20, 32'h0);
        rd("R1 ccls", 8'h2C, 32'h0);
        rd("R1 pen", 8'h30, 32'h0);
        rd("R1 pcls", 8'h3C, 32'h0);
        idle("R1 lines high no enable", 32'hFFFF_FFFF);
        idle("R1 idle", 32'h0);

        // R2 set and clear aliases
        wr("R2 set", 8'h24, 32'h0000_00F0);
        wr("R2 set", 8'h24, 32'h0000_0F00);
        rd("R2 or", 8'h20, 32'h0000_0FF0);
        wr("R2 clr", 8'h28, 32'h0000_0030);
        rd("R2 andnot", 8'h20, 32'h0000_0FC0);
        wr("R2 zero set", 8'h24, 32'h0);
        wr("R2 zero clr", 8'h28, 32'h0);
        rd("R2 zero bits", 8'h20, 32'h0000_0FC0);
        // R10 alias reads
        rd("R10 set alias", 8'h24, 32'h0000_0FC0);
        rd("R10 clr alias", 8'h28, 32'h0000_0FC0);

        // R7 normal routing
        idle("R7 line6", 32'h0000_0040);
        chk("R7 irq high", {31'b0, cpu_irq}, 32'h1);
        idle("R7 disabled line", 32'h0000_0001);
        chk("R7 irq low", {31'b0, cpu_irq}, 32'h0);

        // R6 class to FIQ
        irq_in = 32'h0000_0040;
        wr("R6 class", 8'h2C, 32'h0000_0040);
        chk("R6 fiq", {31'b0, cpu_fiq}, 32'h1);
        chk("R6 irq", {31'b0, cpu_irq}, 32'h0);
        // R9 fast status read and ignored writes
        rd("R9 status", 8'h08, 32'h0000_0040);
        wr("R9 write ignored", 8'h08, 32'hFFFF_FFFF);
        rd("R9 status kept", 8'h08, 32'h0000_0040);
        rd("R9 class kept", 8'h2C, 32'h0000_0040);
        irq_in = 32'h0;
        rd("R9 status cleared", 8'h08, 32'h0);

        // R4 R5 force
        wr("R4 force set", 8'h18, 32'h0000_0100);
        chk("R5 forced pending", {31'b0, cpu_irq}, 32'h1);
        rd("R10 force alias", 8'h1C, 32'h0000_0100);
        wr("R4 force clr", 8'h1C, 32'h0000_0100);
        chk("R4 force dropped", {31'b0, cpu_irq}, 32'h0);
        wr("R3 force load", 8'h14, 32'h8000_0080);
        rd("R3 force base", 8'h14, 32'h8000_0080);
        wr("R4 force clr all", 8'h1C, 32'hFFFF_FFFF);

        // R8 coprocessor
        wr("R8 cop set", 8'h34, 32'h0000_0003);
        idle("R8 cop line1", 32'h0000_0002);
        chk("R8 cop irq", {31'b0, cop_irq}, 32'h1);
        wr("R8 cop class", 8'h3C, 32'hFFFF_FFFF);
        chk("R8 class no effect", {31'b0, cop_irq}, 32'h1);
        rd("R8 cop class read", 8'h3C, 32'hFFFF_FFFF);
        wr("R8 cop clr", 8'h38, 32'h0000_0002);
        rd("R8 cop mask", 8'h30, 32'h0000_0001);
        irq_in = 32'h0;

        // R2 clear all, R3 base load
        wr("R2 clr all", 8'h28, 32'hFFFF_FFFF);
        rd("R2 all off", 8'h20, 32'h0);
        wr("R3 cen load", 8'h20, 32'h1234_5678);
        rd("R3 cen base", 8'h20, 32'h1234_5678);
        wr("R3 pen load", 8'h30, 32'hA5A5_0000);
        rd("R3 pen base", 8'h30, 32'hA5A5_0000);

        // R11 unmapped
        wr("R11 wr 04", 8'h04, 32'hFFFF_FFFF);
        wr("R11 wr 21", 8'h21, 32'hFFFF_FFFF);
        wr("R11 wr 40", 8'h40, 32'hFFFF_FFFF);
        wr("R11 wr FC", 8'hFC, 32'hFFFF_FFFF);
        rd("R11 rd 04", 8'h04, 32'h0);
        rd("R11 rd 40", 8'h40, 32'h0);
        rd("R11 cen kept", 8'h20, 32'h1234_5678);
        rd("R11 frc kept", 8'h14, 32'h0);

        // random mix against the model
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            int pick;
            pick = $urandom_range(0, 15);
            case (pick)
                0: a = 8'h08;  1: a = 8'h14;  2: a = 8'h18;  3: a = 8'h1C;
                4: a = 8'h20;  5: a = 8'h24;  6: a = 8'h28;  7: a = 8'h2C;
                8: a = 8'h30;  9: a = 8'h34; 10: a = 8'h38; 11: a = 8'h3C;
                default: a = 8'($urandom);
            endcase
            d = $urandom & $urandom;
            cycle("R7 R8 random", $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                  a, d, $urandom & $urandom & $urandom);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule